// File: doc/BRIEF.md
# Two-wire register-read bus master

This block is the controller side of a two-wire serial bus, and it performs one register-read transaction each time it is started. An idle-state start pulse latches a 7-bit target address and an 8-bit register index. The block then raises a START condition and sends the address together with a read flag. It sends the register index on the same data line and shifts in one data byte from the target. It acknowledges that byte, holds the clock low for one bit period, and closes the frame with a STOP.

The host sees a one-cycle done strobe when the frame has ended. With it come the returned byte and an error flag, and the flag is set when the target leaves an acknowledge slot high. A missing acknowledge on either the address or the index stops the frame at once. The block does not retry; it issues STOP and reports the failure. The clock line is a push-pull output. The data line is an open-drain inout: the block only ever pulls it low or releases it, and a pull-up on the board supplies the high level.

Bit timing comes from the system clock. Each SCL bit is split into four equal quarters, and each quarter lasts `SCL_HALF/2` system clocks. SCL is low for the first two quarters and high for the last two. The data line is updated at the start of the second quarter and is sampled on the system clock edge at which SCL rises.

Top module: `i2c_regrd_master`

## Requirements
- R1: After reset, and whenever no transaction is active, `scl_o` is 1, SDA is released, `done_o` is 0, `nack_o` is 0 and `rd_data_o` is 0.
- R2: When `start_i` is high while the block is idle, a transaction begins. SDA falls while SCL is high (START), and only after that does SCL fall.
- R3: The first byte on SDA is the 7-bit address, MSB first, followed by a read flag of value 1, for 8 SCL clocks in total.
- R4: On the ninth SCL clock of the address byte and of the index byte, the block releases SDA. It reads SDA low at that SCL rise as an acknowledge and SDA high as a missing acknowledge.
- R5: After the address is acknowledged, the 8-bit register index follows on SDA, MSB first.
- R6: After the index is acknowledged, the block releases SDA for 8 SCL clocks and captures the bits MSB first at each SCL rise. It pulls SDA low on the ninth clock as its acknowledge, keeps SCL low for one bit period, and then makes a STOP: SDA rises while SCL is high.
- R7: While SCL stays high, SDA changes only as part of START or STOP. A complete frame therefore has exactly two such changes.
- R8: If the address is not acknowledged, the block does not resend it. STOP follows the ninth clock directly, so the frame has 10 SCL rising edges. `done_o` pulses with `nack_o` set, and `rd_data_o` keeps its previous value.
- R9: If the register index is not acknowledged, the block ends in the same way after 19 SCL rising edges, with `nack_o` set and `rd_data_o` unchanged.
- R10: `done_o` is a one-cycle pulse that comes after STOP. `nack_o` and `rd_data_o` change only in the cycle in which `done_o` is high, and they then hold their values.
- R11: A `start_i` pulse that arrives during a transaction is ignored. The active frame runs to its end and no second frame follows.
- R12: SCL stays high for `SCL_HALF` system clocks on each data bit, and a successful frame has 28 SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin one read; used only when idle |
| dev_addr_i | input | 7 | Target address, latched at start |
| reg_idx_i | input | 8 | Register index, latched at start |
| rd_data_o | output | 8 | Byte returned by the last successful read |
| done_o | output | 1 | One-cycle strobe at the end of a frame |
| nack_o | output | 1 | Last frame ended on a missing acknowledge |
| scl_o | output | 1 | Bus clock |
| sda_io | inout | 1 | Open-drain bus data |

## Verification
The assertions take for granted that the data line goes high whenever nothing pulls it low. They also assume that a target changes SDA only while SCL is low, because the master's capture point is the SCL rising edge. The bench meets both conditions: it pulls the shared line up and attaches a target model that drives only in reaction to SCL falling edges. That model can refuse the address or the index on demand. The host's start pulse is driven between clock edges and lasts exactly one cycle, and it comes both in the idle state and in the middle of a frame.

// File: rtl/i2c_regrd_pkg.sv
// Shared definitions for the two-wire register-read master.
// Assumes the bus carries 7-bit addresses and 8-bit bytes.
package i2c_regrd_pkg;

    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = 8;
    localparam int BIT_CW  = $clog2(BYTE_W + 1);
    localparam logic RD_FLAG = 1'b1;

    // Frame sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_INDEX,
        ST_DATA,
        ST_HOLD,
        ST_STOP
    } seq_state_e;

endpackage

// File: rtl/i2c_regrd_tick.sv
// Quarter-bit tick generator.
// Emits a one-cycle tick every QTR system clocks while run_i is high, and
// resets its count whenever run_i is low. Assumes QTR >= 2.
module i2c_regrd_tick #(
    parameter int QTR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR - 1);

    logic [CW-1:0] cnt_q;

    // Count system clocks within one quarter bit
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/i2c_regrd_shreg.sv
// Byte shift register shared by transmit and receive.
// A parallel load wins over a shift. A transmit shift moves the MSB out and
// fills with 0; a receive shift appends the sampled bit at the LSB.
module i2c_regrd_shreg
    import i2c_regrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [BYTE_W-1:0] ld_val_i,
    input  logic              shl_i,
    input  logic              samp_i,
    input  logic              samp_bit_i,
    output logic              msb_o,
    output logic [BYTE_W-1:0] byte_o
);

    logic [BYTE_W-1:0] sr_q;

    // Load, shift out or shift in one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (ld_i) begin
            sr_q <= ld_val_i;
        end else if (shl_i) begin
            sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
        end else if (samp_i) begin
            sr_q <= {sr_q[BYTE_W-2:0], samp_bit_i};
        end
    end

    assign msb_o  = sr_q[BYTE_W-1];
    assign byte_o = sr_q;

endmodule

// File: rtl/i2c_regrd_seq.sv
// Frame sequencer for one register read.
// Steps through START, address byte, index byte, data byte, one idle bit and
// STOP in quarter-bit steps. Assumes tick_i pulses once per quarter while the
// frame is active. SDA is updated in the second low quarter so that it never
// moves on the same edge as SCL.
module i2c_regrd_seq
    import i2c_regrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic [BYTE_W-1:0] reg_idx_i,
    input  logic              tick_i,
    input  logic              sda_in_i,
    input  logic              msb_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              run_o,
    output logic              ld_o,
    output logic [BYTE_W-1:0] ld_val_o,
    output logic              shl_o,
    output logic              samp_o,
    output logic              scl_o,
    output logic              sda_low_o,
    output logic              done_o,
    output logic              nack_o,
    output logic [BYTE_W-1:0] rd_data_o,
    output seq_state_e        state_o
);

    localparam logic [BIT_CW-1:0] ACK_SLOT = BIT_CW'(BYTE_W);

    seq_state_e        st_q;
    logic [1:0]        qtr_q;
    logic [BIT_CW-1:0] bit_q;
    logic [BYTE_W-1:0] idx_q;
    logic              bad_ack_q;
    logic              err_q;
    logic              sda_low_q;
    logic              done_q;
    logic              nack_q;
    logic [BYTE_W-1:0] data_q;

    logic accept;
    logic qend;
    logic rise_pt;
    logic tx_byte;
    logic byte_st;
    logic in_ack;
    logic sda_want;

    assign accept  = (st_q == ST_IDLE) && start_i;
    assign qend    = tick_i && (qtr_q == 2'd3);
    assign rise_pt = tick_i && (qtr_q == 2'd1);
    assign tx_byte = (st_q == ST_ADDR) || (st_q == ST_INDEX);
    assign byte_st = tx_byte || (st_q == ST_DATA);
    assign in_ack  = (bit_q == ACK_SLOT);

    // Pick the SDA pull-down wanted for the current quarter
    always_comb begin
        unique case (st_q)
            ST_START: sda_want = (qtr_q != 2'd0);
            ST_ADDR,
            ST_INDEX: sda_want = in_ack ? 1'b0 : ~msb_i;
            ST_DATA:  sda_want = in_ack;
            ST_HOLD:  sda_want = 1'b1;
            ST_STOP:  sda_want = (qtr_q < 2'd2);
            default:  sda_want = 1'b0;
        endcase
    end

    // Derive SCL from the phase and quarter
    always_comb begin
        unique case (st_q)
            ST_START: scl_o = (qtr_q != 2'd3);
            ST_ADDR,
            ST_INDEX,
            ST_DATA:  scl_o = (qtr_q >= 2'd2);
            ST_HOLD:  scl_o = 1'b0;
            ST_STOP:  scl_o = (qtr_q != 2'd0);
            default:  scl_o = 1'b1;
        endcase
    end

    // Hold SDA through the first low quarter of a bit, then follow the want
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_low_q <= 1'b0;
        end else if (!(byte_st && qtr_q == 2'd0)) begin
            sda_low_q <= sda_want;
        end
    end

    // Capture the acknowledge level at the SCL rise of the ninth clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_ack_q <= 1'b0;
        end else if (accept) begin
            bad_ack_q <= 1'b0;
        end else if (rise_pt && tx_byte && in_ack) begin
            bad_ack_q <= sda_in_i;
        end
    end

    // Advance phase, quarter and bit count; report at the end of STOP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            qtr_q  <= 2'd0;
            bit_q  <= '0;
            idx_q  <= '0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            nack_q <= 1'b0;
            data_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                st_q  <= ST_START;
                qtr_q <= 2'd0;
                bit_q <= '0;
                idx_q <= reg_idx_i;
                err_q <= 1'b0;
            end else if (tick_i) begin
                qtr_q <= qtr_q + 2'd1;
                if (qtr_q == 2'd3) begin
                    unique case (st_q)
                        ST_START: begin
                            st_q  <= ST_ADDR;
                            bit_q <= '0;
                        end
                        ST_ADDR, ST_INDEX: begin
                            if (!in_ack) begin
                                bit_q <= bit_q + 1'b1;
                            end else begin
                                bit_q <= '0;
                                if (bad_ack_q) begin
                                    st_q  <= ST_STOP;
                                    err_q <= 1'b1;
                                end else begin
                                    st_q <= (st_q == ST_ADDR) ? ST_INDEX : ST_DATA;
                                end
                            end
                        end
                        ST_DATA: begin
                            if (!in_ack) begin
                                bit_q <= bit_q + 1'b1;
                            end else begin
                                bit_q <= '0;
                                st_q  <= ST_HOLD;
                            end
                        end
                        ST_HOLD: st_q <= ST_STOP;
                        ST_STOP: begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                            nack_q <= err_q;
                            if (!err_q) begin
                                data_q <= byte_i;
                            end
                        end
                        default: st_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // Drive the shift register controls
    always_comb begin
        ld_o     = 1'b0;
        ld_val_o = idx_q;
        if (accept) begin
            ld_o     = 1'b1;
            ld_val_o = {dev_addr_i, RD_FLAG};
        end else if (qend && st_q == ST_ADDR && in_ack && !bad_ack_q) begin
            ld_o = 1'b1;
        end
    end

    assign shl_o     = qend && tx_byte && !in_ack;
    assign samp_o    = rise_pt && (st_q == ST_DATA) && !in_ack;
    assign run_o     = (st_q != ST_IDLE);
    assign sda_low_o = sda_low_q;
    assign done_o    = done_q;
    assign nack_o    = nack_q;
    assign rd_data_o = data_q;
    assign state_o   = st_q;

endmodule

// File: rtl/i2c_regrd_master.sv
// Top of the two-wire register-read master.
// Joins the quarter tick generator, the shift register and the frame
// sequencer, and drives SDA as an open-drain line. Assumes an external
// pull-up on SDA and SCL_HALF even and at least 4.
module i2c_regrd_master
    import i2c_regrd_pkg::*;
#(
    parameter int SCL_HALF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic [BYTE_W-1:0] reg_idx_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              done_o,
    output logic              nack_o,
    output logic              scl_o,
    inout  wire               sda_io
);

    localparam int QTR = SCL_HALF / 2;

    logic              run;
    logic              tick;
    logic              ld;
    logic [BYTE_W-1:0] ld_val;
    logic              shl;
    logic              samp;
    logic              msb;
    logic [BYTE_W-1:0] sr_byte;
    logic              sda_low;
    logic              sda_in;
    seq_state_e        seq_state;

    i2c_regrd_tick #(.QTR(QTR)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    i2c_regrd_shreg u_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_i       (ld),
        .ld_val_i   (ld_val),
        .shl_i      (shl),
        .samp_i     (samp),
        .samp_bit_i (sda_in),
        .msb_o      (msb),
        .byte_o     (sr_byte)
    );

    i2c_regrd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dev_addr_i (dev_addr_i),
        .reg_idx_i  (reg_idx_i),
        .tick_i     (tick),
        .sda_in_i   (sda_in),
        .msb_i      (msb),
        .byte_i     (sr_byte),
        .run_o      (run),
        .ld_o       (ld),
        .ld_val_o   (ld_val),
        .shl_o      (shl),
        .samp_o     (samp),
        .scl_o      (scl_o),
        .sda_low_o  (sda_low),
        .done_o     (done_o),
        .nack_o     (nack_o),
        .rd_data_o  (rd_data_o),
        .state_o    (seq_state)
    );

    // Open-drain pad: pull low or release
    assign sda_io = sda_low ? 1'b0 : 1'bz;
    assign sda_in = sda_io;

endmodule

// File: rtl/i2c_regrd_chk.sv
// Protocol checker for the register-read master, bound to the top module.
// Assumes the SDA pull-up is present; checks only master-side behaviour.
module i2c_regrd_chk
    import i2c_regrd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              scl_o,
    input logic              done_o,
    input logic              nack_o,
    input logic [BYTE_W-1:0] rd_data_o,
    input logic              sda_low,
    input seq_state_e        st
);

    logic busy;
    assign busy = (st != ST_IDLE);

    // R1
    idle_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && !sda_low));

    // R2
    start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_i));

    // R7
    sda_still_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && !$stable(sda_low)) |-> (st == ST_START || st == ST_STOP));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    nack_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nack_o) |-> done_o);

    // R10
    data_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data_o) |-> (done_o && !nack_o));

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st != ST_STOP && start_i) |=> busy);

endmodule

bind i2c_regrd_master i2c_regrd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .scl_o     (scl_o),
    .done_o    (done_o),
    .nack_o    (nack_o),
    .rd_data_o (rd_data_o),
    .sda_low   (sda_low),
    .st        (seq_state)
);

// File: tb/i2c_regrd_master_tb.sv
`timescale 1ns/1ps
module i2c_regrd_master_tb;

    localparam int SCL_HALF = 8;
    localparam logic [6:0] TGT_ADDR = 7'h3C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] idx = '0;
    logic [7:0] rd_data;
    logic       done;
    logic       nack;
    logic       scl;
    wire        sda_bus;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pullup (sda_bus);

    i2c_regrd_master #(.SCL_HALF(SCL_HALF)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .dev_addr_i (addr),
        .reg_idx_i  (idx),
        .rd_data_o  (rd_data),
        .done_o     (done),
        .nack_o     (nack),
        .scl_o      (scl),
        .sda_io     (sda_bus)
    );

    // ---------------- target model and bus monitor ----------------
    logic       slv_low = 1'b0;
    logic       refuse_idx = 1'b0;
    logic       prev_scl = 1'b1;
    logic       prev_sda = 1'b1;
    logic       sel = 1'b0;
    logic [7:0] sh = '0;
    logic [7:0] addr_rx = '0;
    logic [7:0] idx_rx = '0;
    logic       mack = 1'b0;
    int         bpos = 0;
    int         bnum = 0;
    int         rises = 0;
    int         high_moves = 0;
    int         hcnt = 0;
    int         last_high = 0;

    assign sda_bus = slv_low ? 1'b0 : 1'bz;

    function automatic logic [7:0] tgt_reg(input logic [7:0] i);
        return i ^ 8'hA5;
    endfunction

    always @(negedge clk) begin
        logic s;
        s = (sda_bus !== 1'b0);
        if (scl && prev_scl && (s != prev_sda)) high_moves++;
        if (scl && !prev_scl) begin
            rises++;
            hcnt = 1;
        end else if (scl) begin
            hcnt++;
        end else if (prev_scl) begin
            last_high = hcnt;
        end
        if (scl && prev_scl && prev_sda && !s) begin
            bpos = 0; bnum = 0; sel = 1'b0; slv_low = 1'b0; mack = 1'b0;
        end else if (scl && !prev_scl) begin
            if (bpos < 8 && bnum < 2) sh = {sh[6:0], s};
            if (bpos == 8 && bnum == 2) mack = !s;
            if (bpos == 8) begin bpos = 0; bnum++; end
            else bpos++;
            if (bpos == 8 && bnum == 0) addr_rx = sh;
            if (bpos == 8 && bnum == 1) idx_rx = sh;
        end else if (!scl && prev_scl) begin
            slv_low = 1'b0;
            if (bpos == 8 && bnum == 0) begin
                sel = (sh[7:1] == TGT_ADDR) && sh[0];
                slv_low = sel;
            end else if (bpos == 8 && bnum == 1) begin
                slv_low = sel && !refuse_idx;
            end else if (bnum == 2 && bpos < 8 && sel) begin
                slv_low = !tgt_reg(idx_rx)[7 - bpos];
            end
        end
        prev_scl = scl;
        prev_sda = s;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [6:0] a, input logic [7:0] i);
        @(negedge clk);
        addr = a; idx = i; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for done; returns 0 on watchdog expiry
    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        if (!ok) chk(1'b0, "watchdog", 0, 1);
    endtask

    task automatic check_pulse_end(input string req);
        @(negedge clk);
        chk(done == 1'b0, req, done, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(scl == 1'b1, "R1 scl idle", scl, 1);
        chk(sda_bus !== 1'b0, "R1 sda released", sda_bus, 1);
        chk(done == 1'b0 && nack == 1'b0, "R1 flags", {done, nack}, 0);
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    endtask

    task automatic t_read_ok(input logic [7:0] i);
        int r0, m0;
        bit ok;
        refuse_idx = 1'b0;
        r0 = rises; m0 = high_moves;
        pulse_start(TGT_ADDR, i);
        wait_done(ok);
        if (ok) begin
            chk(addr_rx == {TGT_ADDR, 1'b1}, "R3 address byte", addr_rx, {TGT_ADDR, 1'b1});
            chk(idx_rx == i, "R5 index byte", idx_rx, i);
            chk(rd_data == tgt_reg(i), "R6 read data", rd_data, tgt_reg(i));
            chk(mack == 1'b1, "R6 master ack", mack, 1);
            chk(nack == 1'b0, "R4 ack accepted", nack, 0);
            chk(rises - r0 == 28, "R12 scl rises", rises - r0, 28);
            chk(last_high == SCL_HALF, "R12 scl high time", last_high, SCL_HALF);
            chk(high_moves - m0 == 2, "R7 sda moves on high scl", high_moves - m0, 2);
            check_pulse_end("R10 done width");
            chk(scl == 1'b1 && sda_bus !== 1'b0, "R2 bus idle after stop", scl, 1);
        end
    endtask

    task automatic t_addr_nack();
        int r0, m0;
        logic [7:0] keep;
        bit ok;
        keep = rd_data;
        r0 = rises; m0 = high_moves;
        pulse_start(TGT_ADDR ^ 7'h01, 8'h10);
        wait_done(ok);
        if (ok) begin
            chk(nack == 1'b1, "R8 nack flag", nack, 1);
            chk(rises - r0 == 10, "R8 no resend", rises - r0, 10);
            chk(rd_data == keep, "R8 data kept", rd_data, keep);
            chk(high_moves - m0 == 2, "R7 abort start/stop", high_moves - m0, 2);
            check_pulse_end("R10 done width abort");
        end
        repeat (40) @(negedge clk);
        chk(nack == 1'b1, "R10 nack held", nack, 1);
    endtask

    task automatic t_index_nack();
        int r0;
        logic [7:0] keep;
        bit ok;
        keep = rd_data;
        refuse_idx = 1'b1;
        r0 = rises;
        pulse_start(TGT_ADDR, 8'h77);
        wait_done(ok);
        if (ok) begin
            chk(nack == 1'b1, "R9 nack flag", nack, 1);
            chk(rises - r0 == 19, "R9 scl rises", rises - r0, 19);
            chk(rd_data == keep, "R9 data kept", rd_data, keep);
        end
        refuse_idx = 1'b0;
    endtask

    task automatic t_busy_start();
        int r0;
        bit ok;
        r0 = rises;
        pulse_start(TGT_ADDR, 8'h3E);
        repeat (100) @(negedge clk);
        pulse_start(TGT_ADDR, 8'hC1);
        wait_done(ok);
        if (ok) begin
            chk(rd_data == tgt_reg(8'h3E), "R11 first frame data", rd_data, tgt_reg(8'h3E));
            chk(nack == 1'b0, "R11 nack clear after success", nack, 0);
        end
        repeat (200) @(negedge clk);
        chk(rises - r0 == 28, "R11 no second frame", rises - r0, 28);
    endtask

    initial begin
        t_reset();
        t_read_ok(8'h96);
        t_read_ok(8'h00);
        t_read_ok(8'hFF);
        t_addr_nack();
        t_read_ok(8'h5B);
        t_index_nack();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule